// File: doc/BRIEF.md
# Test Access Port with Fixed Opcode Map

This block is the boundary-scan test port of a memory device. It follows the IEEE 1149.1 controller: a sixteen-state machine that advances on each rising edge of the test clock under the mode-select input. The machine sits in front of a three-bit instruction register and three data paths: a one-bit bypass stage, a 32-bit identification word, and a boundary chain whose length is a parameter. There is no dedicated test-reset pin. An asynchronous power-on reset input puts the controller in Test-Logic-Reset, and five rising edges with mode-select high reach the same state from anywhere.

The opcode map is fixed. Two of the boundary-chain instructions put the device's data pins into high impedance, so that every pad can be sampled as an input. A third boundary-chain instruction samples the pads and leaves the data pins driving. Three codes select the bypass stage, and the one reserved code falls back to it as well. The pads are represented by a parallel capture input and a parallel update output of the boundary chain. The serial output changes on the falling edge of the test clock and carries a separate enable signal.

Top module: `scan_tap_ctrl`

## Requirements
- R1: While `por_n` is low and right after it rises, the controller is in Test-Logic-Reset with IDCODE (code 001) active. In that state `tdo_oe`, `pins_hiz` and `pad_drive` are all 0, and the first data scan returns the identification word.
- R2: Five rising TCK edges with TMS high bring the controller to Test-Logic-Reset from any state. At the next rising edge in that state the active instruction becomes IDCODE.
- R3: In Capture-IR the instruction shift stage loads 001. During Shift-IR the stage is shifted out least significant bit first, and TDI enters at the top bit.
- R4: A newly shifted instruction takes effect only at the rising edge in Update-IR. Until then the decoded outputs keep their previous values.
- R5: The instruction code selects the data path. Codes 000, 010 and 100 select the boundary chain of `BSR_LEN` bits. Code 001 selects the 32-bit identification register. Codes 011, 110 and 111 select the one-bit bypass stage.
- R6: The reserved code 101 selects the one-bit bypass stage, so the scan path stays one bit long.
- R7: Capture-DR clears the bypass stage to 0. During Shift-DR the stage delays TDI by one bit, and after Shift-DR is left it holds the last bit shifted in.
- R8: The identification word reads revision[31:28], configuration[27:18], vendor field[17:12] and manufacturer code[11:1], with bit 0 set to 1. It is shifted out least significant bit first.
- R9: `pins_hiz` is 1 exactly when code 000 or 010 is active. Under code 100 the pins keep driving. `pad_drive` is 1 only under code 000.
- R10: With the boundary chain selected, Capture-DR loads `bsr_capture`, and bit 0 leaves first. Update-DR copies the shifted contents to `bsr_update`. A data scan through any other path leaves `bsr_update` unchanged.
- R11: TDO changes only on falling TCK edges. `tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial test data in |
| bsr_capture | input | BSR_LEN | Pad values loaded into the boundary chain in Capture-DR |
| tdo | output | 1 | Serial test data out, updated on falling TCK |
| tdo_oe | output | 1 | Enable for the serial output driver |
| pins_hiz | output | 1 | Forces the device data pins to high impedance |
| pad_drive | output | 1 | Pads take their values from `bsr_update` |
| bsr_update | output | BSR_LEN | Boundary chain update stage |

## Verification
Every one of the eight opcodes is loaded and then scanned over the path length it should select. Comparing the serial output stream against the identification word, the captured pad vector, or the one-bit-delayed input tells the three paths apart, including the reserved code. Random opcode sequences with random scan data and random pad captures check that boundary updates happen only through the chain. Directed sequences cover the reset states, the Pause/Exit2 return into Shift-DR that shows the bypass stage holding its bit, and five-ones escapes from inside Shift-DR and Shift-IR.

// File: rtl/tap_pkg.sv
package tap_pkg;

   localparam int IR_W = 3;

   typedef enum logic [3:0] {
      ST_RESET     = 4'h0,
      ST_IDLE      = 4'h1,
      ST_SEL_DR    = 4'h2,
      ST_CAP_DR    = 4'h3,
      ST_SHIFT_DR  = 4'h4,
      ST_EX1_DR    = 4'h5,
      ST_PAUSE_DR  = 4'h6,
      ST_EX2_DR    = 4'h7,
      ST_UPD_DR    = 4'h8,
      ST_SEL_IR    = 4'h9,
      ST_CAP_IR    = 4'hA,
      ST_SHIFT_IR  = 4'hB,
      ST_EX1_IR    = 4'hC,
      ST_PAUSE_IR  = 4'hD,
      ST_EX2_IR    = 4'hE,
      ST_UPD_IR    = 4'hF
   } tap_state_e;

   typedef enum logic [1:0] {
      PATH_BYP = 2'd0,
      PATH_ID  = 2'd1,
      PATH_BSR = 2'd2
   } dr_path_e;

   localparam logic [IR_W-1:0] OP_PAD_DRIVE = 3'b000;
   localparam logic [IR_W-1:0] OP_IDENT     = 3'b001;
   localparam logic [IR_W-1:0] OP_SAMPLE_HZ = 3'b010;
   localparam logic [IR_W-1:0] OP_BYP_A     = 3'b011;
   localparam logic [IR_W-1:0] OP_SAMPLE    = 3'b100;
   localparam logic [IR_W-1:0] OP_RSVD      = 3'b101;
   localparam logic [IR_W-1:0] OP_BYP_B     = 3'b110;
   localparam logic [IR_W-1:0] OP_BYP_C     = 3'b111;

   localparam logic [IR_W-1:0] IR_CAP_PAT   = 3'b001;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
   import tap_pkg::*;
(
   input  logic       tck,
   input  logic       por_n,
   input  logic       tms,
   output tap_state_e state
);

   tap_state_e nxt;

   always_comb begin
      nxt = state;
      case (state)
         ST_RESET:    nxt = tms ? ST_RESET    : ST_IDLE;
         ST_IDLE:     nxt = tms ? ST_SEL_DR   : ST_IDLE;
         ST_SEL_DR:   nxt = tms ? ST_SEL_IR   : ST_CAP_DR;
         ST_CAP_DR:   nxt = tms ? ST_EX1_DR   : ST_SHIFT_DR;
         ST_SHIFT_DR: nxt = tms ? ST_EX1_DR   : ST_SHIFT_DR;
         ST_EX1_DR:   nxt = tms ? ST_UPD_DR   : ST_PAUSE_DR;
         ST_PAUSE_DR: nxt = tms ? ST_EX2_DR   : ST_PAUSE_DR;
         ST_EX2_DR:   nxt = tms ? ST_UPD_DR   : ST_SHIFT_DR;
         ST_UPD_DR:   nxt = tms ? ST_SEL_DR   : ST_IDLE;
         ST_SEL_IR:   nxt = tms ? ST_RESET    : ST_CAP_IR;
         ST_CAP_IR:   nxt = tms ? ST_EX1_IR   : ST_SHIFT_IR;
         ST_SHIFT_IR: nxt = tms ? ST_EX1_IR   : ST_SHIFT_IR;
         ST_EX1_IR:   nxt = tms ? ST_UPD_IR   : ST_PAUSE_IR;
         ST_PAUSE_IR: nxt = tms ? ST_EX2_IR   : ST_PAUSE_IR;
         ST_EX2_IR:   nxt = tms ? ST_UPD_IR   : ST_SHIFT_IR;
         ST_UPD_IR:   nxt = tms ? ST_SEL_DR   : ST_IDLE;
         default:     nxt = ST_RESET;
      endcase
   end

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) state <= ST_RESET;
      else        state <= nxt;
   end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
   import tap_pkg::*;
(
   input  logic            tck,
   input  logic            por_n,
   input  logic            tdi,
   input  tap_state_e      state,
   output logic [IR_W-1:0] ir_q,
   output logic [IR_W-1:0] ir_sh,
   output dr_path_e        dr_path,
   output logic            hiz,
   output logic            drive
);

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) begin
         ir_sh <= IR_CAP_PAT;
         ir_q  <= OP_IDENT;
      end else begin
         case (state)
            ST_CAP_IR:   ir_sh <= IR_CAP_PAT;
            ST_SHIFT_IR: ir_sh <= {tdi, ir_sh[IR_W-1:1]};
            ST_UPD_IR:   ir_q  <= ir_sh;
            ST_RESET:    ir_q  <= OP_IDENT;
            default:     ;
         endcase
      end
   end

   always_comb begin
      dr_path = PATH_BYP;
      hiz     = 1'b0;
      drive   = 1'b0;
      case (ir_q)
         OP_PAD_DRIVE: begin dr_path = PATH_BSR; hiz = 1'b1; drive = 1'b1; end
         OP_SAMPLE_HZ: begin dr_path = PATH_BSR; hiz = 1'b1; end
         OP_SAMPLE:    dr_path = PATH_BSR;
         OP_IDENT:     dr_path = PATH_ID;
         default:      dr_path = PATH_BYP;
      endcase
   end

endmodule

// File: rtl/tap_dr.sv
module tap_dr
   import tap_pkg::*;
#(
   parameter int          BSR_LEN = 121,
   parameter logic [31:0] ID_WORD = 32'h0000_0001
)(
   input  logic               tck,
   input  logic               por_n,
   input  logic               tdi,
   input  tap_state_e         state,
   input  dr_path_e           dr_path,
   input  logic [BSR_LEN-1:0] bsr_cap_in,
   output logic [BSR_LEN-1:0] bsr_upd_out,
   output logic               dr_so
);

   localparam int ID_W = 32;

   logic cap, shf, upd;
   assign cap = (state == ST_CAP_DR);
   assign shf = (state == ST_SHIFT_DR);
   assign upd = (state == ST_UPD_DR);

   logic byp;
   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)                  byp <= 1'b0;
      else if (dr_path == PATH_BYP) begin
         if (cap)      byp <= 1'b0;
         else if (shf) byp <= tdi;
      end
   end

   logic [ID_W-1:0] id_sh;
   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)                 id_sh <= '0;
      else if (dr_path == PATH_ID) begin
         if (cap)      id_sh <= ID_WORD;
         else if (shf) id_sh <= {tdi, id_sh[ID_W-1:1]};
      end
   end

   logic [BSR_LEN-1:0] bsr_sh;
   logic [BSR_LEN-1:0] bsr_nxt;
   logic               bsr_on;
   assign bsr_nxt = {tdi, bsr_sh[BSR_LEN-1:1]};
   assign bsr_on  = (dr_path == PATH_BSR);

   for (genvar g = 0; g < BSR_LEN; g++) begin : g_cell
      always_ff @(posedge tck or negedge por_n) begin
         if (!por_n) begin
            bsr_sh[g]      <= 1'b0;
            bsr_upd_out[g] <= 1'b0;
         end else if (bsr_on) begin
            if (cap)      bsr_sh[g]      <= bsr_cap_in[g];
            else if (shf) bsr_sh[g]      <= bsr_nxt[g];
            if (upd)      bsr_upd_out[g] <= bsr_sh[g];
         end
      end
   end

   always_comb begin
      case (dr_path)
         PATH_ID:  dr_so = id_sh[0];
         PATH_BSR: dr_so = bsr_sh[0];
         default:  dr_so = byp;
      endcase
   end

endmodule

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
   import tap_pkg::*;
#(
   parameter int          BSR_LEN  = 121,
   parameter logic [3:0]  ID_REV   = 4'h1,
   parameter logic [9:0]  ID_CFG   = 10'h1C3,
   parameter logic [5:0]  ID_VEND  = 6'h0B,
   parameter logic [10:0] ID_MFR   = 11'h35A
)(
   input  logic               tck,
   input  logic               por_n,
   input  logic               tms,
   input  logic               tdi,
   input  logic [BSR_LEN-1:0] bsr_capture,
   output logic               tdo,
   output logic               tdo_oe,
   output logic               pins_hiz,
   output logic               pad_drive,
   output logic [BSR_LEN-1:0] bsr_update
);

   localparam logic [31:0] ID_WORD = {ID_REV, ID_CFG, ID_VEND, ID_MFR, 1'b1};

   if (BSR_LEN < 2) begin : g_bad_len
      $error("scan_tap_ctrl: BSR_LEN must be at least 2");
   end

   tap_state_e      state;
   logic [IR_W-1:0] ir_q;
   logic [IR_W-1:0] ir_sh;
   dr_path_e        dr_path;
   logic            dr_so;

   tap_fsm u_fsm (
      .tck   (tck),
      .por_n (por_n),
      .tms   (tms),
      .state (state)
   );

   tap_ir u_ir (
      .tck     (tck),
      .por_n   (por_n),
      .tdi     (tdi),
      .state   (state),
      .ir_q    (ir_q),
      .ir_sh   (ir_sh),
      .dr_path (dr_path),
      .hiz     (pins_hiz),
      .drive   (pad_drive)
   );

   tap_dr #(
      .BSR_LEN (BSR_LEN),
      .ID_WORD (ID_WORD)
   ) u_dr (
      .tck         (tck),
      .por_n       (por_n),
      .tdi         (tdi),
      .state       (state),
      .dr_path     (dr_path),
      .bsr_cap_in  (bsr_capture),
      .bsr_upd_out (bsr_update),
      .dr_so       (dr_so)
   );

   always_ff @(negedge tck or negedge por_n) begin
      if (!por_n) begin
         tdo    <= 1'b0;
         tdo_oe <= 1'b0;
      end else if (state == ST_SHIFT_IR) begin
         tdo    <= ir_sh[0];
         tdo_oe <= 1'b1;
      end else if (state == ST_SHIFT_DR) begin
         tdo    <= dr_so;
         tdo_oe <= 1'b1;
      end else begin
         tdo_oe <= 1'b0;
      end
   end

endmodule

// File: rtl/scan_tap_ctrl_chk.sv
module scan_tap_ctrl_chk
   import tap_pkg::*;
(
   input logic            tck,
   input logic            por_n,
   input logic            tms,
   input tap_state_e      state,
   input logic [IR_W-1:0] ir_q,
   input logic [IR_W-1:0] ir_sh,
   input logic            tdo_oe,
   input logic            pins_hiz
);

   logic [2:0] ones;
   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)          ones <= '0;
      else if (!tms)       ones <= '0;
      else if (ones != 3'd7) ones <= ones + 3'd1;
   end

   AST_RESET_LOADS_IDENT: assert property (@(posedge tck) disable iff (!por_n)
      (state == ST_RESET) |=> (ir_q == OP_IDENT)); // R2

   AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!por_n)
      (ones >= 3'd5) |-> (state == ST_RESET)); // R2

   AST_CAPTURE_IR_PATTERN: assert property (@(posedge tck) disable iff (!por_n)
      (state == ST_CAP_IR) |=> (ir_sh == IR_CAP_PAT)); // R3

   AST_IR_HOLDS: assert property (@(posedge tck) disable iff (!por_n)
      (state != ST_UPD_IR && state != ST_RESET) |=> $stable(ir_q)); // R4

   AST_HIZ_MOVES_AT_UPDATE: assert property (@(posedge tck) disable iff (!por_n)
      !$stable(pins_hiz) |-> ($past(state) == ST_UPD_IR || $past(state) == ST_RESET)); // R9

   AST_OE_ONLY_SHIFT: assert property (@(posedge tck) disable iff (!por_n)
      tdo_oe |-> (state == ST_SHIFT_IR || state == ST_SHIFT_DR)); // R11

endmodule

bind scan_tap_ctrl scan_tap_ctrl_chk u_chk (
   .tck      (tck),
   .por_n    (por_n),
   .tms      (tms),
   .state    (state),
   .ir_q     (ir_q),
   .ir_sh    (ir_sh),
   .tdo_oe   (tdo_oe),
   .pins_hiz (pins_hiz)
);

// File: tb/scan_tap_ctrl_test.sv
module scan_tap_ctrl_test;

   localparam int PERIOD = 20;
   localparam int BSR    = 121;
   localparam logic [31:0] EXP_ID = {4'h1, 10'h1C3, 6'h0B, 11'h35A, 1'b1};

   logic           tck = 1'b0;
   logic           por_n;
   logic           tms;
   logic           tdi;
   logic [BSR-1:0] cap_in;
   logic           tdo;
   logic           tdo_oe;
   logic           pins_hiz;
   logic           pad_drive;
   logic [BSR-1:0] upd;

   int n_tests = 0;
   int n_fail  = 0;
   int rise_changes = 0;
   bit done = 1'b0;

   always #(PERIOD/2) tck = ~tck;

   scan_tap_ctrl #(
      .BSR_LEN (BSR),
      .ID_REV  (4'h1),
      .ID_CFG  (10'h1C3),
      .ID_VEND (6'h0B),
      .ID_MFR  (11'h35A)
   ) uut (
      .tck         (tck),
      .por_n       (por_n),
      .tms         (tms),
      .tdi         (tdi),
      .bsr_capture (cap_in),
      .tdo         (tdo),
      .tdo_oe      (tdo_oe),
      .pins_hiz    (pins_hiz),
      .pad_drive   (pad_drive),
      .bsr_update  (upd)
   );

   // R11: TDO may only move while TCK is low (falling-edge update)
   always @(tdo) if (tck === 1'b1 && por_n === 1'b1) rise_changes++;

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick(input logic m, input logic d, output logic o, output logic e);
      o = tdo;
      e = tdo_oe;
      tms = m;
      tdi = d;
      @(posedge tck);
      @(negedge tck);
      #1;
   endtask

   task automatic tk(input logic m);
      logic o, e;
      tick(m, 1'b1, o, e);
   endtask

   task automatic load_ir(input logic [2:0] code, output logic [2:0] cap_bits,
                          output logic hiz_mid);
      logic o, e;
      tk(1); tk(1); tk(0); tk(0);
      for (int i = 0; i < 3; i++) begin
         tick(i == 2, code[i], o, e);
         cap_bits[i] = o;
      end
      hiz_mid = pins_hiz;
      tk(1); tk(0);
   endtask

   task automatic scan_dr(input logic [BSR-1:0] din, input int len,
                          output logic [BSR-1:0] dout, output bit oe_ok);
      logic o, e;
      dout = '0;
      oe_ok = 1'b1;
      tk(1); tk(0); tk(0);
      for (int i = 0; i < len; i++) begin
         tick(i == len - 1, din[i], o, e);
         dout[i] = o;
         if (e !== 1'b1) oe_ok = 1'b0;
      end
      tk(1); tk(0);
   endtask

   function automatic int path_len(input logic [2:0] code);
      case (code)
         3'b001:                 return 32;
         3'b000, 3'b010, 3'b100: return BSR;
         default:                return 8;
      endcase
   endfunction

   function automatic logic [BSR-1:0] exp_dr(input logic [2:0] code,
         input logic [BSR-1:0] din, input logic [BSR-1:0] cap, input int len);
      logic [BSR-1:0] r;
      r = '0;
      case (code)
         3'b001:                 r[31:0] = EXP_ID;
         3'b000, 3'b010, 3'b100: r = cap;
         default: for (int i = 1; i < len; i++) r[i] = din[i-1];
      endcase
      return r;
   endfunction

   function automatic string path_tag(input logic [2:0] code);
      case (code)
         3'b001:                 return "R5/R8 ident";
         3'b000, 3'b010, 3'b100: return "R5/R10 boundary";
         3'b101:                 return "R6 reserved";
         default:                return "R5/R7 bypass";
      endcase
   endfunction

   function automatic logic [BSR-1:0] rand_vec();
      logic [BSR-1:0] v;
      for (int i = 0; i < BSR; i++) v[i] = 1'($urandom % 2);
      return v;
   endfunction

   task automatic check_decode(input logic [2:0] code);
      chk(pins_hiz == (code == 3'b000 || code == 3'b010), "R9 pins_hiz",
          128'(pins_hiz), 128'(code == 3'b000 || code == 3'b010));
      chk(pad_drive == (code == 3'b000), "R9 pad_drive",
          128'(pad_drive), 128'(code == 3'b000));
   endtask

   task automatic do_dr(input logic [2:0] code);
      logic [BSR-1:0] din, dout, expv, mask, prev;
      bit oe_ok;
      int len;
      len = path_len(code);
      din = rand_vec();
      cap_in = rand_vec();
      prev = upd;
      scan_dr(din, len, dout, oe_ok);
      expv = exp_dr(code, din, cap_in, len);
      mask = '0;
      for (int i = 0; i < len; i++) mask[i] = 1'b1;
      chk((dout & mask) == (expv & mask), path_tag(code),
          128'(dout & mask), 128'(expv & mask));
      chk(oe_ok, "R11 tdo_oe in Shift-DR", 128'(oe_ok), 128'(1));
      if (len == BSR)
         chk(upd == din, "R10 update copy", 128'(upd), 128'(din));
      else
         chk(upd == prev, "R10 update untouched", 128'(upd), 128'(prev));
   endtask

   initial begin : main
      logic [2:0] cb;
      logic hm, prev_hiz, o, e;
      logic [BSR-1:0] din, dout;
      bit oe_ok;

      void'($urandom(32'd2024));
      por_n = 1'b0;
      tms = 1'b1;
      tdi = 1'b1;
      cap_in = '0;
      repeat (3) @(negedge tck);
      #1;
      chk(tdo_oe == 1'b0 && pins_hiz == 1'b0 && pad_drive == 1'b0, "R1 in reset",
          128'({tdo_oe, pins_hiz, pad_drive}), 128'(0));
      por_n = 1'b1;
      @(negedge tck); #1;
      chk(tdo_oe == 1'b0 && pins_hiz == 1'b0 && pad_drive == 1'b0, "R1 after reset",
          128'({tdo_oe, pins_hiz, pad_drive}), 128'(0));
      tk(0);
      chk(tdo_oe == 1'b0, "R11 idle oe", 128'(tdo_oe), 128'(0));
      scan_dr('0, 32, dout, oe_ok);
      chk(dout[31:0] == EXP_ID, "R1 R8 first scan ident", 128'(dout[31:0]), 128'(EXP_ID));

      // R3 / R4: capture pattern and late update
      prev_hiz = pins_hiz;
      load_ir(3'b000, cb, hm);
      chk(cb == 3'b001, "R3 capture pattern", 128'(cb), 128'(3'b001));
      chk(hm == prev_hiz, "R4 hiz before update", 128'(hm), 128'(prev_hiz));
      check_decode(3'b000);
      prev_hiz = pins_hiz;
      load_ir(3'b100, cb, hm);
      chk(hm == prev_hiz, "R4 hiz held in Exit1-IR", 128'(hm), 128'(prev_hiz));

      // every opcode: decode and path
      for (int c = 0; c < 8; c++) begin
         load_ir(3'(c), cb, hm);
         chk(cb == 3'b001, "R3 capture pattern", 128'(cb), 128'(3'b001));
         check_decode(3'(c));
         do_dr(3'(c));
      end

      // R7: bypass holds last bit through Pause/Exit2 return to Shift-DR
      load_ir(3'b011, cb, hm);
      din = rand_vec();
      tk(1); tk(0); tk(0);
      for (int i = 0; i < 5; i++) tick(i == 4, din[i], o, e);
      tk(0); tk(1); tk(0);
      tick(1, 1'b0, o, e);
      chk(o == din[4], "R7 bypass hold", 128'(o), 128'(din[4]));
      tk(1); tk(0);

      // R2: five ones from inside Shift-DR
      load_ir(3'b010, cb, hm);
      tk(1); tk(0); tk(0);
      for (int i = 0; i < 5; i++) tk(1);
      chk(tdo_oe == 1'b0, "R2 reset reached oe", 128'(tdo_oe), 128'(0));
      tk(1);
      chk(pins_hiz == 1'b0, "R2 ident after five ones", 128'(pins_hiz), 128'(0));
      tk(0);
      scan_dr('0, 32, dout, oe_ok);
      chk(dout[31:0] == EXP_ID, "R2 ident scan", 128'(dout[31:0]), 128'(EXP_ID));

      // R2: five ones from inside Shift-IR
      load_ir(3'b000, cb, hm);
      tk(1); tk(1); tk(0); tk(0);
      for (int i = 0; i < 6; i++) tk(1);
      chk(pins_hiz == 1'b0 && pad_drive == 1'b0, "R2 from Shift-IR",
          128'({pins_hiz, pad_drive}), 128'(0));
      tk(0);

      // random opcode sequence
      for (int n = 0; n < 30; n++) begin
         logic [2:0] code;
         code = 3'($urandom % 8);
         load_ir(code, cb, hm);
         chk(cb == 3'b001, "R3 capture pattern", 128'(cb), 128'(3'b001));
         check_decode(code);
         do_dr(code);
      end

      chk(rise_changes == 0, "R11 tdo on falling edge", 128'(rise_changes), 128'(0));

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : watchdog
      #(PERIOD * 150000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule